// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

The block gathers 32 system request lines into a master pending word, which a disable mask gates. It steers the enabled requests to one selectable target CPU. A parameter table assigns each request a 4-bit priority level. Each CPU owns a 16-bit level vector output, and that output is registered.

Every CPU also holds a local pending word. Software can set and clear bits in it. The same word also takes that CPU's timer request and the level bits of system requests raised while that CPU is the target. Bits 31:17 of the local word drive level bits 15:1 directly.

A plain register bus reaches both kinds of register window. It has a write strobe, a master/per-CPU window select, an address, write data and combinational read data. The per-CPU windows are one 4 KB page apart. Request and timer inputs act on their edges: a rising edge sets bits and a falling edge clears them.

Top module: `irqr_route_ctl`

## Requirements
- R1: Reset, asynchronous and active low, sets the following. All pending words are zero. The disable mask is 0x004DFF80. The target CPU is 0. All level outputs are zero.
- R2: In the per-CPU window, address bits [13:12] select the CPU and address bits [3:2] select the register. Register 0 reads that CPU's local pending word. A write to register 1 clears the written one-bits. A write to register 2 sets them.
- R3: A master-window read of register 0 returns master pending with bit 31 forced to 0. A read of register 1 returns the disable mask. The master register index is address bits [4:2].
- R4: A master write to register 2 clears the written bits of the disable mask. A master write to register 3 sets them and also clears the same bits of master pending.
- R5: A master write to register 4 loads the target CPU from the written value ANDed with N_CPU-1.
- R6: A rising edge on request n sets master pending bit n. It also sets bit level(n) of the current target's local pending word. A falling edge clears both of those bits. With the default table, level(n) = (n mod 15) + 1.
- R7: A rising edge on timer input c sets local bit level(TIMER_SRC) of CPU c. The default TIMER_SRC is 10, which gives bit 11. A falling edge clears that bit.
- R8: In the target CPU's level vector, each source that is both pending and enabled sets bit level(n). System sources set no bits in any other CPU's vector.
- R9: When disable-mask bit 31 is set, no system source reaches any level vector.
- R10: For every CPU, local pending bits 31:17 drive level bits 15:1. Local bit 16 has no effect.
- R11: Reads of undefined registers return 0. These are master registers 2 to 7 and per-CPU registers 1 to 3. Writes to master registers 0, 1, 5 to 7 and to per-CPU registers 0 and 3 change nothing.
- R12: A level output changes one clock after the state change that causes it. A register write updates state at the write's edge, and the level follows at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_mst_i | input | 1 | 1 selects the master window, 0 selects a per-CPU window |
| bus_addr_i | input | 12+log2(N_CPU) | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for the addressed register |
| req_i | input | 32 | System request lines |
| timer_i | input | N_CPU | Per-CPU timer requests |
| lvl_o | output | N_CPU*16 | Level vectors, CPU c at bits [16c+15:16c] |

## Verification
A table pass exercises both register windows and checks the following:
- set and clear patterns with mixed upper and lower bits;
- undefined indices, for reads and for ignored writes;
- disable-mask toggling that includes bit 31.

Directed tests then raise single requests whose levels differ, so a wrong table lookup or a wrong bit position shows on the output.

Retargeting while a request is held separates two things: the routing of live master pending, which follows the new target, and the local bit latched at the old target, which stays. Bit 31 is tested in two roles: as a master pending bit it is hidden on read but still routed, and as a mask bit it acts as a global block. The timer and bit-16 cases check that per-CPU local state stays isolated from the other CPUs.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int unsigned SRC_N = 32;
  localparam int unsigned LVL_N = 16;
  localparam int unsigned LVL_W = 4;
  localparam logic [31:0] DIS_RST = ~32'hFFB2007F;

  typedef logic [SRC_N*LVL_W-1:0] lvl_map_t;

  typedef enum logic [1:0] {LOC_PEND = 2'd0, LOC_CLR = 2'd1, LOC_SET = 2'd2} loc_idx_e;
  typedef enum logic [2:0] {
    MST_PEND = 3'd0, MST_DIS = 3'd1, MST_EN = 3'd2, MST_OFF = 3'd3, MST_TGT = 3'd4
  } mst_idx_e;

  function automatic lvl_map_t default_map();
    lvl_map_t m;
    for (int j = 0; j < SRC_N; j++) m[j*LVL_W +: LVL_W] = 4'((j % 15) + 1);
    return m;
  endfunction

  // OR of one-hot levels for every set source bit
  function automatic logic [LVL_N-1:0] lvl_of_mask(logic [SRC_N-1:0] m, lvl_map_t map);
    logic [LVL_N-1:0] v;
    v = '0;
    for (int j = 0; j < SRC_N; j++)
      if (m[j]) v[map[j*LVL_W +: LVL_W]] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irqr_edge.sv
module irqr_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/irqr_master.sv
module irqr_master import irqr_pkg::*; #(
  parameter int unsigned N_CPU = 4,
  localparam int unsigned CPU_W = $clog2(N_CPU)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       idx_i,
  input  logic [31:0]      wdata_i,
  input  logic [31:0]      rise_i,
  input  logic [31:0]      fall_i,
  output logic [31:0]      pend_o,
  output logic [31:0]      dis_o,
  output logic [CPU_W-1:0] tgt_o
);
  logic [31:0]      pend_q, dis_q, pend_d, dis_d;
  logic [CPU_W-1:0] tgt_q, tgt_d;
  logic             en_wr, off_wr, tgt_wr;

  assign en_wr  = wr_i && (idx_i == MST_EN);
  assign off_wr = wr_i && (idx_i == MST_OFF);
  assign tgt_wr = wr_i && (idx_i == MST_TGT);

  always_comb begin
    dis_d = dis_q;
    if (en_wr)  dis_d = dis_q & ~wdata_i;
    if (off_wr) dis_d = dis_q | wdata_i;
    pend_d = pend_q & ~(off_wr ? wdata_i : 32'h0);
    pend_d = (pend_d & ~fall_i) | rise_i;
    tgt_d  = tgt_wr ? wdata_i[CPU_W-1:0] : tgt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      dis_q  <= DIS_RST;
      tgt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      dis_q  <= dis_d;
      tgt_q  <= tgt_d;
    end
  end

  assign pend_o = pend_q;
  assign dis_o  = dis_q;
  assign tgt_o  = tgt_q;
endmodule

// File: rtl/irqr_local.sv
module irqr_local (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] clr_i,
  input  logic [31:0] set_i,
  input  logic [31:0] ev_clr_i,
  input  logic [31:0] ev_set_i,
  output logic [31:0] pend_o
);
  logic [31:0] pend_q, pend_d;

  // bus write first, then input events; a set wins over a clear
  assign pend_d = ((((pend_q & ~clr_i) | set_i) & ~ev_clr_i) | ev_set_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqr_level.sv
module irqr_level import irqr_pkg::*; #(
  parameter lvl_map_t LVL_MAP = default_map()
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             is_tgt_i,
  input  logic [31:0]      mpend_i,
  input  logic [31:0]      dis_i,
  input  logic [31:0]      lpend_i,
  output logic [LVL_N-1:0] lvl_o
);
  logic [31:0]      act;
  logic             sys_on;
  logic [LVL_N-1:0] vec, lvl_q;

  assign act    = mpend_i & ~dis_i;
  assign sys_on = is_tgt_i && (|act) && !dis_i[31];

  always_comb begin
    vec = lpend_i[31:16] & 16'hFFFE;
    if (sys_on) vec = vec | lvl_of_mask(act, LVL_MAP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= vec;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/irqr_route_ctl.sv
module irqr_route_ctl import irqr_pkg::*; #(
  parameter int unsigned N_CPU     = 4,
  parameter lvl_map_t    LVL_MAP   = default_map(),
  parameter int unsigned TIMER_SRC = 10,
  localparam int unsigned CPU_W    = $clog2(N_CPU),
  localparam int unsigned ADDR_W   = 12 + CPU_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_wr_i,
  input  logic                   bus_mst_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [31:0]            bus_wdata_i,
  output logic [31:0]            bus_rdata_o,
  input  logic [SRC_N-1:0]       req_i,
  input  logic [N_CPU-1:0]       timer_i,
  output logic [N_CPU*LVL_N-1:0] lvl_o
);
  localparam int unsigned TMR_LVL = int'(LVL_MAP[TIMER_SRC*LVL_W +: LVL_W]);
  localparam logic [31:0] TMR_BIT = 32'(1) << TMR_LVL;

  logic [CPU_W-1:0]    cpu_sel, tgt;
  logic [1:0]          loc_idx;
  logic [2:0]          mst_idx;
  logic [31:0]         req_rise, req_fall, mpend, dis, sys_set, sys_clr;
  logic [N_CPU-1:0]    tmr_rise, tmr_fall;
  logic [31:0]         lpend [N_CPU];
  logic [N_CPU*32-1:0] lpend_flat;
  logic                unused_addr;

  assign cpu_sel     = bus_addr_i[12 +: CPU_W];
  assign loc_idx     = bus_addr_i[3:2];
  assign mst_idx     = bus_addr_i[4:2];
  assign unused_addr = ^{bus_addr_i[11:5], bus_addr_i[1:0]};

  irqr_edge #(.W(SRC_N)) i_req_edge (
    .clk_i, .rst_ni, .sig_i(req_i), .rise_o(req_rise), .fall_o(req_fall)
  );

  irqr_edge #(.W(N_CPU)) i_tmr_edge (
    .clk_i, .rst_ni, .sig_i(timer_i), .rise_o(tmr_rise), .fall_o(tmr_fall)
  );

  irqr_master #(.N_CPU(N_CPU)) i_master (
    .clk_i, .rst_ni,
    .wr_i   (bus_wr_i && bus_mst_i),
    .idx_i  (mst_idx),
    .wdata_i(bus_wdata_i),
    .rise_i (req_rise),
    .fall_i (req_fall),
    .pend_o (mpend),
    .dis_o  (dis),
    .tgt_o  (tgt)
  );

  assign sys_set = {16'h0, lvl_of_mask(req_rise, LVL_MAP)};
  assign sys_clr = {16'h0, lvl_of_mask(req_fall, LVL_MAP)};

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic        hit, is_tgt;
    logic [31:0] clr, set, ev_clr, ev_set;

    assign hit    = bus_wr_i && !bus_mst_i && (cpu_sel == CPU_W'(c));
    assign is_tgt = (tgt == CPU_W'(c));
    assign clr    = (hit && loc_idx == LOC_CLR) ? bus_wdata_i : 32'h0;
    assign set    = (hit && loc_idx == LOC_SET) ? bus_wdata_i : 32'h0;
    assign ev_set = (is_tgt ? sys_set : 32'h0) | (tmr_rise[c] ? TMR_BIT : 32'h0);
    assign ev_clr = (is_tgt ? sys_clr : 32'h0) | (tmr_fall[c] ? TMR_BIT : 32'h0);

    irqr_local i_local (
      .clk_i, .rst_ni,
      .clr_i(clr), .set_i(set), .ev_clr_i(ev_clr), .ev_set_i(ev_set),
      .pend_o(lpend[c])
    );

    irqr_level #(.LVL_MAP(LVL_MAP)) i_level (
      .clk_i, .rst_ni,
      .is_tgt_i(is_tgt),
      .mpend_i (mpend),
      .dis_i   (dis),
      .lpend_i (lpend[c]),
      .lvl_o   (lvl_o[c*LVL_N +: LVL_N])
    );

    assign lpend_flat[c*32 +: 32] = lpend[c];
  end

  always_comb begin
    bus_rdata_o = 32'h0;
    if (bus_mst_i) begin
      if (mst_idx == MST_PEND)     bus_rdata_o = {1'b0, mpend[30:0]};
      else if (mst_idx == MST_DIS) bus_rdata_o = dis;
    end else if (loc_idx == LOC_PEND) begin
      bus_rdata_o = lpend[cpu_sel];
    end
  end
endmodule

// File: rtl/irqr_route_chk.sv
module irqr_route_chk #(
  parameter int unsigned N_CPU   = 4,
  parameter int unsigned TMR_LVL = 11,
  localparam int unsigned CPU_W  = $clog2(N_CPU),
  localparam int unsigned ADDR_W = 12 + CPU_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_wr_i,
  input logic                bus_mst_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [31:0]         bus_wdata_i,
  input logic [31:0]         bus_rdata_o,
  input logic [31:0]         req_i,
  input logic [N_CPU-1:0]    timer_i,
  input logic [CPU_W-1:0]    tgt,
  input logic [31:0]         dis,
  input logic [31:0]         mpend,
  input logic [N_CPU*32-1:0] lpend_flat
);
  logic [31:0]      req_d;
  logic [N_CPU-1:0] tmr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d <= '0;
      tmr_d <= '0;
    end else begin
      req_d <= req_i;
      tmr_d <= timer_i;
    end
  end

  // R3
  mst_pend_b31_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_mst_i && bus_addr_i[4:2] == 3'd0) |-> !bus_rdata_o[31]);

  // R11
  undef_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_mst_i && bus_addr_i[4:2] >= 3'd2) || (!bus_mst_i && bus_addr_i[3:2] != 2'd0))
    |-> (bus_rdata_o == 32'h0));

  // R5
  tgt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_mst_i && bus_addr_i[4:2] == 3'd4)
    |=> (tgt == $past(bus_wdata_i[CPU_W-1:0])));

  // R4
  dis_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_mst_i && bus_addr_i[4:2] == 3'd3)
    |=> (((dis & $past(bus_wdata_i)) == $past(bus_wdata_i)) &&
         ((mpend & $past(bus_wdata_i) & ~$past(req_i & ~req_d)) == 32'h0)));

  // R6
  req_rise_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_i & ~req_d))
    |=> ((mpend & $past(req_i & ~req_d)) == $past(req_i & ~req_d)));

  for (genvar c = 0; c < N_CPU; c++) begin : g_tmr
    // R7
    tmr_rise_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (timer_i[c] && !tmr_d[c]) |=> lpend_flat[c*32 + TMR_LVL]);
  end
endmodule

bind irqr_route_ctl irqr_route_chk #(.N_CPU(N_CPU), .TMR_LVL(TMR_LVL)) i_route_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_wr_i   (bus_wr_i),
  .bus_mst_i  (bus_mst_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .req_i      (req_i),
  .timer_i    (timer_i),
  .tgt        (tgt),
  .dis        (dis),
  .mpend      (mpend),
  .lpend_flat (lpend_flat)
);

// File: tb/test_irqr_route_ctl.sv
`timescale 1ns/1ps
module test_irqr_route_ctl;
  localparam int NC = 4;
  localparam int NV = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_mst = 1'b0;
  logic [13:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [31:0]       req = '0;
  logic [NC-1:0]     timer = '0;
  logic [NC*16-1:0]  lvl;
  int                errors = 0;
  int                checks = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  irqr_route_ctl i_irqr_route_ctl (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_mst_i(bus_mst),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .req_i(req), .timer_i(timer), .lvl_o(lvl)
  );

  // {is_read, master, addr, data, expected}
  localparam logic [79:0] VEC [NV] = '{
    {1'b1, 1'b1, 14'h0000, 32'h0,        32'h0},         // R1 master pending
    {1'b1, 1'b1, 14'h0004, 32'h0,        32'h004DFF80},  // R1 mask
    {1'b0, 1'b1, 14'h0008, 32'hFFFFFFFF, 32'h0},         // R4 enable all
    {1'b1, 1'b1, 14'h0004, 32'h0,        32'h0},         // R3 mask read
    {1'b0, 1'b0, 14'h1008, 32'h00050003, 32'h0},         // R2 set cpu1
    {1'b1, 1'b0, 14'h1000, 32'h0,        32'h00050003},
    {1'b0, 1'b0, 14'h1004, 32'h00010001, 32'h0},         // R2 clear
    {1'b1, 1'b0, 14'h1000, 32'h0,        32'h00040002},
    {1'b1, 1'b0, 14'h100C, 32'h0,        32'h0},         // R11
    {1'b0, 1'b0, 14'h100C, 32'hFFFFFFFF, 32'h0},
    {1'b1, 1'b0, 14'h1000, 32'h0,        32'h00040002},
    {1'b1, 1'b0, 14'h0000, 32'h0,        32'h0},         // R2 cpu0 untouched
    {1'b0, 1'b1, 14'h000C, 32'h80000000, 32'h0},         // R4 set mask
    {1'b1, 1'b1, 14'h0004, 32'h0,        32'h80000000},
    {1'b0, 1'b1, 14'h0008, 32'h80000000, 32'h0},
    {1'b0, 1'b1, 14'h0010, 32'h00000007, 32'h0},         // R5 target = 3
    {1'b0, 1'b1, 14'h0014, 32'h00000001, 32'h0},         // R11 ignored write
    {1'b1, 1'b1, 14'h0014, 32'h0,        32'h0},
    {1'b0, 1'b0, 14'h1004, 32'hFFFFFFFF, 32'h0},
    {1'b1, 1'b0, 14'h1000, 32'h0,        32'h0}
  };

  function automatic int lvl_of(int n);
    return (n % 15) + 1;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", rq, act, exp);
    end
  endtask

  task automatic wr(bit mst, logic [13:0] a, logic [31:0] d);
    @(negedge clk);
    bus_mst = mst; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(bit mst, logic [13:0] a, output logic [31:0] d);
    bus_mst = mst; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic logic [31:0] lv(int c);
    return {16'h0, lvl[c*16 +: 16]};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NC; c++) chk("R1 level reset", lv(c), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][79]) begin
        rd(VEC[i][78], VEC[i][77:64], r);
        chk($sformatf("R1-R5/R11 table row %0d", i), r, VEC[i][31:0]);
      end else begin
        wr(VEC[i][78], VEC[i][77:64], VEC[i][63:32]);
      end
    end

    // R6 R8: target 3, request 5
    req[5] = 1'b1; settle(2);
    rd(1'b1, 14'h0000, r); chk("R6 master pend", r, 32'h20);
    rd(1'b0, 14'h3000, r); chk("R6 local cpu3", r, 32'(1) << lvl_of(5));
    chk("R8 level cpu3", lv(3), 32'(1) << lvl_of(5));
    chk("R8 level cpu0", lv(0), 32'h0);

    // R9 global disable
    wr(1'b1, 14'h000C, 32'h80000000); settle(1);
    chk("R9 level blocked", lv(3), 32'h0);
    rd(1'b1, 14'h0000, r); chk("R9 pend kept", r, 32'h20);

    // R12 one cycle after the write
    wr(1'b1, 14'h0008, 32'h80000000);
    chk("R12 level not yet", lv(3), 32'h0);
    settle(1);
    chk("R12 level after", lv(3), 32'h40);

    // R4 disable clears pending
    wr(1'b1, 14'h000C, 32'h20);
    rd(1'b1, 14'h0000, r); chk("R4 pend cleared", r, 32'h0);
    rd(1'b1, 14'h0004, r); chk("R4 mask set", r, 32'h20);
    settle(1);
    chk("R4 level gone", lv(3), 32'h0);
    req[5] = 1'b0; settle(2);
    rd(1'b0, 14'h3000, r); chk("R6 fall clears local", r, 32'h0);
    wr(1'b1, 14'h0008, 32'h20);

    // R3 bit 31 hidden but routed
    req[31] = 1'b1; settle(2);
    rd(1'b1, 14'h0000, r); chk("R3 bit31 hidden", r, 32'h0);
    rd(1'b0, 14'h3000, r); chk("R6 local bit31 level", r, 32'(1) << lvl_of(31));
    chk("R8 level bit31", lv(3), 32'(1) << lvl_of(31));
    req[31] = 1'b0; settle(2);
    chk("R6 fall level", lv(3), 32'h0);

    // R5 retarget with a held request
    wr(1'b1, 14'h0010, 32'h5);
    req[0] = 1'b1; settle(2);
    rd(1'b0, 14'h1000, r); chk("R5 local cpu1", r, 32'h2);
    chk("R5 level cpu1", lv(1), 32'h2);
    chk("R8 level cpu3 idle", lv(3), 32'h0);
    wr(1'b1, 14'h0010, 32'h2); settle(1);
    chk("R5 level cpu2", lv(2), 32'h2);
    chk("R5 level cpu1 off", lv(1), 32'h0);
    req[0] = 1'b0; settle(2);
    chk("R6 fall cpu2", lv(2), 32'h0);
    rd(1'b0, 14'h1000, r); chk("R6 old target kept", r, 32'h2);
    wr(1'b0, 14'h1004, 32'hFFFFFFFF);

    // R7 timer
    timer[2] = 1'b1; settle(2);
    rd(1'b0, 14'h2000, r); chk("R7 timer set", r, 32'h800);
    rd(1'b0, 14'h1000, r); chk("R7 other cpu", r, 32'h0);
    timer[2] = 1'b0; settle(2);
    rd(1'b0, 14'h2000, r); chk("R7 timer clear", r, 32'h0);

    // R10 upper local bits
    wr(1'b0, 14'h0008, 32'h80010000); settle(1);
    chk("R10 level cpu0", lv(0), 32'h8000);
    chk("R10 level cpu1", lv(1), 32'h0);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(1'b1, 14'h0004, r); chk("R1 mask reset", r, 32'h004DFF80);
    rd(1'b0, 14'h0000, r); chk("R1 local reset", r, 32'h0);
    chk("R1 level reset", lv(0), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule